// File: doc/BRIEF.md
# Sleep State and Power Button Controller

This block keeps track of the system power state (working S0, standby S1, suspend-to-RAM S3, suspend-to-disk S4, soft-off S5). It drives three active-low power-plane cut signals from that state. Software moves the system into sleep by pulsing a request that carries the target state. A raw, bouncy, active-low power button is synchronised and debounced. A clean press while the system works raises a one-cycle interrupt request, which asks software to start a sleep. A clean press while the system sleeps raises a one-cycle wake pulse and returns the system to S0. Holding the button long enough forces soft-off from any state, once per press.

An active-low thermal trip input bypasses every handshake and forces S5 immediately after its synchroniser. The trip has priority over the button and over software. The debounce and hold windows are parameters in clock cycles. The defaults correspond to 16 ms and 4 s at 50 MHz, and a bench can shorten them.

Top module: `pwr_sleep_ctl`

## Requirements
- R1: A button level change acts only after it has been seen on DEB_CYC consecutive synchronised samples. A low glitch shorter than that produces no pulse and no state change.
- R2: A debounced press while in S0 gives exactly one cycle of `irq_req`, and the state stays S0.
- R3: A debounced press while in S1, S3, S4 or S5 gives exactly one cycle of `wake_pulse`, and the state becomes S0 on the same edge.
- R4: When the debounced button stays pressed for HOLD_CYC cycles, the state becomes S5 from any state. This happens once per press. Nothing further happens until the button is released and then debounced pressed again.
- R5: A low `therm_trip_n`, after SYNC_STAGES synchroniser flops, forces S5 on the next edge without any pulse. While the trip is low, presses and software requests have no effect.
- R6: `cut_s3_n` is low in S3, S4 and S5. `cut_s4_n` is low in S4 and S5. `cut_s5_n` is low only in S5. All three are high in S0 and S1.
- R7: A one-cycle `sleep_req` in S0 moves the state to the target on the next edge. The `sleep_tgt` encoding is 3'd1 = S1, 3'd3 = S3, 3'd4 = S4, 3'd5 = S5. Any other code, or a request made outside S0, is ignored.
- R8: After reset the state is S0, all cut outputs are high and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_btn_n | input | 1 | Raw power button, low when pressed |
| therm_trip_n | input | 1 | Thermal trip, low forces soft-off |
| sleep_req | input | 1 | One-cycle software sleep request |
| sleep_tgt | input | 3 | Target state code for `sleep_req` |
| cut_s3_n | output | 1 | Plane cut for S3 and deeper, active low |
| cut_s4_n | output | 1 | Plane cut for S4 and deeper, active low |
| cut_s5_n | output | 1 | Plane cut for S5, active low |
| irq_req | output | 1 | One-cycle interrupt request on a press in S0 |
| wake_pulse | output | 1 | One-cycle wake indication on a press while sleeping |

## Verification
The pulse assertions assume that two debounced presses are never on adjacent cycles. The debouncer guarantees this whenever DEB_CYC is at least two, and the bench keeps DEB_CYC well above that. The trip and override properties assume that the trip input is held for at least one clock. The bench therefore always drives the trip and button at the falling edge, for whole cycles. The bench also holds the button for durations chosen clearly shorter or clearly longer than the debounce and hold windows.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

   typedef enum logic [2:0] {
      PS_WORK = 3'd0,
      PS_STBY = 3'd1,
      PS_RAM  = 3'd3,
      PS_DISK = 3'd4,
      PS_OFF  = 3'd5
   } pstate_e;

   localparam int NUM_PLANES = 3;
   localparam int FIRST_CUT  = 3;

   function automatic logic tgt_legal(input logic [2:0] code);
      return (code == 3'd1) || (code == 3'd3) || (code == 3'd4) || (code == 3'd5);
   endfunction

endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("psc_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/psc_debounce.sv
module psc_debounce #(
   parameter int CYC = 800000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic level_o,
   output logic fall_o
);
   localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o <= 1'b1;
         cnt     <= '0;
         fall_o  <= 1'b0;
      end else begin
         fall_o <= 1'b0;
         if (level_i == level_o) begin
            cnt <= '0;
         end else if (cnt == CW'(CYC - 1)) begin
            level_o <= level_i;
            cnt     <= '0;
            fall_o  <= level_o;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/psc_hold.sv
module psc_hold #(
   parameter int CYC = 200000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic held_i,
   output logic fire_o
);
   localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

   logic [CW-1:0] cnt;
   logic          spent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         spent  <= 1'b0;
         fire_o <= 1'b0;
      end else begin
         fire_o <= 1'b0;
         if (!held_i) begin
            cnt   <= '0;
            spent <= 1'b0;
         end else if (!spent) begin
            if (cnt == CW'(CYC - 1)) begin
               fire_o <= 1'b1;
               spent  <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
   import pwr_sleep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trip_n_i,
   input  logic       ovr_i,
   input  logic       press_i,
   input  logic       req_i,
   input  logic [2:0] tgt_i,
   output pstate_e    state_o,
   output logic       irq_o,
   output logic       wake_o
);
   pstate_e nxt;
   logic    nxt_irq, nxt_wake;

   always_comb begin
      nxt      = state_o;
      nxt_irq  = 1'b0;
      nxt_wake = 1'b0;
      if (!trip_n_i) begin
         nxt = PS_OFF;
      end else if (ovr_i) begin
         nxt = PS_OFF;
      end else if (press_i) begin
         if (state_o == PS_WORK) begin
            nxt_irq = 1'b1;
         end else begin
            nxt      = PS_WORK;
            nxt_wake = 1'b1;
         end
      end else if (req_i && (state_o == PS_WORK) && tgt_legal(tgt_i)) begin
         nxt = pstate_e'(tgt_i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= PS_WORK;
         irq_o   <= 1'b0;
         wake_o  <= 1'b0;
      end else begin
         state_o <= nxt;
         irq_o   <= nxt_irq;
         wake_o  <= nxt_wake;
      end
   end
endmodule

// File: rtl/psc_plane_dec.sv
module psc_plane_dec
   import pwr_sleep_pkg::*;
(
   input  pstate_e                 state_i,
   output logic [NUM_PLANES-1:0]   cut_n_o
);
   logic [2:0] code;
   assign code = state_i;

   for (genvar g = 0; g < NUM_PLANES; g++) begin : g_plane
      localparam logic [2:0] THR = 3'(FIRST_CUT + g);
      assign cut_n_o[g] = (code < THR);
   end
endmodule

// File: rtl/pwr_sleep_ctl.sv
module pwr_sleep_ctl
   import pwr_sleep_pkg::*;
#(
   parameter int DEB_CYC     = 800000,
   parameter int HOLD_CYC    = 200000000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_btn_n,
   input  logic       therm_trip_n,
   input  logic       sleep_req,
   input  logic [2:0] sleep_tgt,
   output logic       cut_s3_n,
   output logic       cut_s4_n,
   output logic       cut_s5_n,
   output logic       irq_req,
   output logic       wake_pulse
);
   generate
      if (DEB_CYC < 2) begin : g_bad_deb
         $error("DEB_CYC must be at least 2");
      end
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("HOLD_CYC must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic btn_s, trip_s, btn_lvl, press_p, ovr_p;
   pstate_e state;
   logic [NUM_PLANES-1:0] cut_n;

   psc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_btn_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pwr_btn_n), .q_o(btn_s));

   psc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_trip_sync (
      .clk(clk), .rst_n(rst_n), .d_i(therm_trip_n), .q_o(trip_s));

   psc_debounce #(.CYC(DEB_CYC)) u_deb (
      .clk(clk), .rst_n(rst_n), .level_i(btn_s),
      .level_o(btn_lvl), .fall_o(press_p));

   psc_hold #(.CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .held_i(~btn_lvl), .fire_o(ovr_p));

   psc_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .trip_n_i(trip_s), .ovr_i(ovr_p),
      .press_i(press_p), .req_i(sleep_req), .tgt_i(sleep_tgt),
      .state_o(state), .irq_o(irq_req), .wake_o(wake_pulse));

   psc_plane_dec u_dec (.state_i(state), .cut_n_o(cut_n));

   assign cut_s3_n = cut_n[0];
   assign cut_s4_n = cut_n[1];
   assign cut_s5_n = cut_n[2];
endmodule

// File: rtl/pwr_sleep_chk.sv
module pwr_sleep_chk (
   input logic clk,
   input logic rst_n,
   input logic trip_s,
   input logic ovr_p,
   input logic cut_s3_n,
   input logic cut_s4_n,
   input logic cut_s5_n,
   input logic irq_req,
   input logic wake_pulse
);
   p_nest4_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cut_s4_n |-> !cut_s3_n);
   p_nest5_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cut_s5_n |-> (!cut_s4_n && !cut_s3_n));
   p_irq_work_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (cut_s3_n && cut_s4_n && cut_s5_n && !wake_pulse));
   p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);
   p_wake_work_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (cut_s3_n && cut_s4_n && cut_s5_n));
   p_wake_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);
   p_override_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_p |=> !cut_s5_n);
   p_trip_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !trip_s |=> (!cut_s5_n && !irq_req && !wake_pulse));
endmodule

bind pwr_sleep_ctl pwr_sleep_chk u_chk (
   .clk(clk), .rst_n(rst_n), .trip_s(trip_s), .ovr_p(ovr_p),
   .cut_s3_n(cut_s3_n), .cut_s4_n(cut_s4_n), .cut_s5_n(cut_s5_n),
   .irq_req(irq_req), .wake_pulse(wake_pulse));

// File: tb/sim_pwr_sleep_ctl.sv
module sim_pwr_sleep_ctl;
   localparam int DEB  = 8;
   localparam int HOLD = 40;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn_n = 1'b1;
   logic trip_n = 1'b1;
   logic req = 1'b0;
   logic [2:0] tgt = 3'd0;
   logic s3_n, s4_n, s5_n, irq, wake;

   int n_chk = 0;
   int n_fail = 0;
   int n_irq = 0;
   int n_wake = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pwr_sleep_ctl #(.DEB_CYC(DEB), .HOLD_CYC(HOLD), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .pwr_btn_n(btn_n), .therm_trip_n(trip_n),
      .sleep_req(req), .sleep_tgt(tgt), .cut_s3_n(s3_n), .cut_s4_n(s4_n),
      .cut_s5_n(s5_n), .irq_req(irq), .wake_pulse(wake));

   // behavioural reference model
   int mb[SYNC];
   int mt[SYNC];
   int m_lvl, m_dc, m_press, m_hc, m_spent, m_ovr, m_st, m_irq, m_wake;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (mb[i]) begin mb[i] = 1; mt[i] = 1; end
         m_lvl = 1; m_dc = 0; m_press = 0; m_hc = 0; m_spent = 0; m_ovr = 0;
         m_st = 0; m_irq = 0; m_wake = 0;
      end else begin
         int ns, ni, nw, no, np;
         ns = m_st; ni = 0; nw = 0;
         if (mt[SYNC-1] == 0) ns = 5;
         else if (m_ovr != 0) ns = 5;
         else if (m_press != 0) begin
            if (m_st == 0) ni = 1;
            else begin ns = 0; nw = 1; end
         end else if (req && m_st == 0 &&
                      (tgt == 3'd1 || tgt == 3'd3 || tgt == 3'd4 || tgt == 3'd5))
            ns = int'(tgt);
         no = 0;
         if (m_lvl == 1) begin m_hc = 0; m_spent = 0; end
         else if (m_spent == 0) begin
            if (m_hc == HOLD - 1) begin no = 1; m_spent = 1; end
            else m_hc++;
         end
         np = 0;
         if (mb[SYNC-1] == m_lvl) m_dc = 0;
         else if (m_dc == DEB - 1) begin
            np = m_lvl; m_lvl = mb[SYNC-1]; m_dc = 0;
         end else m_dc++;
         for (int i = SYNC - 1; i > 0; i--) begin mb[i] = mb[i-1]; mt[i] = mt[i-1]; end
         mb[0] = int'(btn_n); mt[0] = int'(trip_n);
         m_st = ns; m_irq = ni; m_wake = nw; m_ovr = no; m_press = np;
      end
   end

   task automatic check(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic int cuts();
      return {29'd0, s3_n, s4_n, s5_n};
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int e;
         case (m_st)
            3: e = 3'b011;
            4: e = 3'b001;
            5: e = 3'b000;
            default: e = 3'b111;
         endcase
         check("R6 cut outputs vs model", cuts(), e);
         check("R2 irq_req vs model", int'(irq), m_irq);
         check("R3 wake_pulse vs model", int'(wake), m_wake);
         if (irq) n_irq++;
         if (wake) n_wake++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(input int len);
      btn_n = 1'b0; tick(len);
      btn_n = 1'b1; tick(DEB + 6);
   endtask

   task automatic ask(input logic [2:0] t);
      req = 1'b1; tgt = t; tick(1);
      req = 1'b0; tgt = 3'd0; tick(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int i0, w0;
      tick(3);
      rst_n = 1'b1;
      tick(2);
      check("R8 reset cuts high", cuts(), 7);
      check("R8 reset no irq", int'(irq), 0);
      check("R8 reset no wake", int'(wake), 0);

      // R1: glitch shorter than window
      i0 = n_irq;
      btn_n = 1'b0; tick(DEB - 3); btn_n = 1'b1; tick(20);
      check("R1 glitch ignored", n_irq - i0, 0);

      // R2: press in S0
      i0 = n_irq; w0 = n_wake;
      press(20);
      check("R2 one irq", n_irq - i0, 1);
      check("R2 no wake", n_wake - w0, 0);
      check("R2 stays S0", cuts(), 7);

      // R7 / R6 / R3: S3 and wake
      ask(3'd3);
      check("R7 entered S3", cuts(), 3'b011);
      w0 = n_wake; press(20);
      check("R3 wake from S3", n_wake - w0, 1);
      check("R3 back to S0", cuts(), 7);

      // R7: illegal code ignored
      ask(3'd2);
      i0 = n_irq; press(20);
      check("R7 code 2 ignored", n_irq - i0, 1);
      ask(3'd7);
      i0 = n_irq; press(20);
      check("R7 code 7 ignored", n_irq - i0, 1);

      // R6 / R7: S4, request outside S0
      ask(3'd4);
      check("R6 S4 cuts", cuts(), 3'b001);
      ask(3'd5);
      check("R7 request outside S0 ignored", cuts(), 3'b001);
      press(20);
      ask(3'd5);
      check("R6 S5 cuts", cuts(), 3'b000);
      w0 = n_wake; press(20);
      check("R3 wake from S5", n_wake - w0, 1);

      // R3: S1
      ask(3'd1);
      check("R6 S1 cuts high", cuts(), 7);
      w0 = n_wake; press(20);
      check("R3 wake from S1", n_wake - w0, 1);

      // R4: override from S0
      i0 = n_irq; w0 = n_wake;
      btn_n = 1'b0; tick(DEB + HOLD + 10);
      check("R4 override to S5", cuts(), 3'b000);
      tick(HOLD + 10);
      check("R4 single irq during hold", n_irq - i0, 1);
      check("R4 no wake while held", n_wake - w0, 0);
      btn_n = 1'b1; tick(DEB + 6);
      check("R4 stays S5 after release", cuts(), 3'b000);
      press(20);
      // R4: override from S3 (wake first, then soft-off)
      ask(3'd3);
      w0 = n_wake;
      btn_n = 1'b0; tick(DEB + HOLD + 10);
      check("R4 override from S3", cuts(), 3'b000);
      check("R4 wake once", n_wake - w0, 1);
      btn_n = 1'b1; tick(DEB + 6);
      press(20);

      // R5: thermal trip
      trip_n = 1'b0; tick(SYNC + 2);
      check("R5 trip forces S5", cuts(), 3'b000);
      w0 = n_wake; press(20);
      check("R5 press ignored during trip", n_wake - w0, 0);
      check("R5 still S5", cuts(), 3'b000);
      trip_n = 1'b1; tick(SYNC + 3);
      check("R5 S5 kept after trip", cuts(), 3'b000);
      press(20);
      ask(3'd4);
      trip_n = 1'b0; tick(1); trip_n = 1'b1; tick(SYNC + 2);
      check("R5 one-cycle trip from S4", cuts(), 3'b000);

      tick(5);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule